// File: doc/BRIEF.md
# Shared Backup Switchover Wrapper

This wrapper lets one reduced-function backup unit stand in for any one of several identical originals while that original is taken out of service for a test. All originals and the backup see one forwarded request bus. Per-unit valid lines pick who takes each request. For each unit, a response multiplexer chooses whether the unit's own outputs or the backup's outputs reach the system. The backup only stands in for one original at a time. It stays unpowered outside a test session.

A session starts with a start pulse that names a unit. The wrapper stalls that original and waits until it reports no outstanding work. It then powers and resets the backup for one cycle and copies the original's pending interrupt status into it. Once both units are quiet, it moves that unit's output select over to the backup. While the backup is in charge, only latency-critical requests reach it: interrupts and programmed I/O. Configuration and boot-ROM requests for that unit are parked in a small queue.

An end pulse reverses the roles. The backup is stalled and drained, its interrupt status is written back into the original, and the select returns to the original. The backup is then switched off, and the parked requests are replayed to the original in arrival order before any new request is taken.

Top module: `backup_switch`

## Requirements
- R1: After reset no original is stalled, the backup is unpowered and not in reset, every output select points at the original, and requests are accepted.
- R2: Every request accepted for a unit that is not being served by the backup appears exactly once, unchanged, on the shared forwarded bus with only that unit's valid line high. The backup sees this same bus.
- R3: On a start pulse the named original is stalled and receives nothing, and new requests for it are refused until it is drained. Only after its busy flag drops is the backup powered with reset high for exactly one cycle. In the following cycle the backup's interrupt-status load strobe pulses, carrying that original's interrupt status.
- R4: The backup power output is low whenever no session is in progress, and it is high from the reset cycle through the restore cycle. The backup never gets a request while unpowered or in reset.
- R5: Request kind is encoded as 0 = interrupt, 1 = programmed I/O, 2 = configuration, 3 = boot ROM. While the backup serves a unit, kinds 0 and 1 for that unit go to the backup only, and kinds 2 and 3 are queued.
- R6: The output select moves to the backup only in a cycle in which both the original's and the backup's busy flags are low. It moves back only after the backup's busy flag is low.
- R7: For the unit under test, the response valid and data come from the backup while the select points at it. For every other unit, and at all other times, they come from that unit's own original.
- R8: After an end pulse the backup is stalled and requests for the unit are refused until the backup is idle. Then, in a single cycle, the original's interrupt-status load strobe pulses with the backup's status, and the select returns to the original.
- R9: After restore the queued requests are forwarded to the original in arrival order, one per cycle. No new request is accepted until the queue is empty.
- R10: When the queue is full, a configuration or boot-ROM request for the unit under test is refused and held at the input, and critical requests for that unit are still accepted.
- R11: Requests and responses of units other than the one under test pass through unchanged during every phase of a session except replay.
- R12: A start pulse that arrives while a session is in progress is ignored. The stalled unit and the select do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| testStart | input | 1 | Pulse: begin a session on testUnit |
| testUnit | input | UNIT_W | Index of the original to take out of service |
| testEnd | input | 1 | Pulse: end the session and restore the original |
| unitIsolated | output | 1 | Output select currently points at the backup |
| reqValid | input | 1 | Incoming request valid |
| reqUnit | input | UNIT_W | Target original of the request |
| reqKind | input | 2 | 0 interrupt, 1 programmed I/O, 2 configuration, 3 boot ROM |
| reqData | input | DATA_W | Request payload |
| reqReady | output | 1 | Request accepted this cycle |
| fwdKind | output | 2 | Kind on the shared forwarded bus |
| fwdData | output | DATA_W | Payload on the shared forwarded bus |
| origReqValid | output | NUM_UNITS | Per-original request valid |
| origStall | output | NUM_UNITS | Per-original stall |
| origBusy | input | NUM_UNITS | Per-original outstanding-work flag |
| origRspValid | input | NUM_UNITS | Per-original response valid |
| origRspData | input | NUM_UNITS*DATA_W | Per-original response data, unit i at bits i*DATA_W |
| origIntStatus | input | NUM_UNITS*INT_W | Per-original pending interrupt status |
| origIntLoad | output | NUM_UNITS | Per-original interrupt-status load strobe |
| origIntData | output | INT_W | Status written back into the original |
| bkPowerOn | output | 1 | Backup power enable |
| bkReset | output | 1 | Backup reset |
| bkStall | output | 1 | Backup stall during drain |
| bkReqValid | output | 1 | Backup request valid |
| bkBusy | input | 1 | Backup outstanding-work flag |
| bkRspValid | input | 1 | Backup response valid |
| bkRspData | input | DATA_W | Backup response data |
| bkIntStatus | input | INT_W | Backup pending interrupt status |
| bkIntLoad | output | 1 | Backup interrupt-status load strobe |
| bkIntData | output | INT_W | Status copied into the backup |
| rspValid | output | NUM_UNITS | Per-unit response valid after the select |
| rspData | output | NUM_UNITS*DATA_W | Per-unit response data after the select |

## Verification
The properties rely on several assumptions about the environment. Each original takes a forwarded request in any cycle its stall is low. The busy flags honestly report outstanding work, so a select change on a quiet cycle cannot split a response. testUnit names an existing unit, and the end pulse comes only while the backup is in charge. The stimulus holds busy flags high for several cycles across the drain and switch points so that the wait states are exercised. It pulses start and end only at legal moments, except for one deliberate start during a session. It fills the parking queue exactly to its depth, so the refusal and the later in-order replay are both observed.

// File: rtl/backup_switch_pkg.sv
package backup_switch_pkg;

  // request kinds: bit 1 clear means latency-critical
  localparam logic [1:0] KIND_IRQ  = 2'd0;
  localparam logic [1:0] KIND_PIO  = 2'd1;
  localparam logic [1:0] KIND_CFG  = 2'd2;
  localparam logic [1:0] KIND_BOOT = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_DRAIN, S_POWER, S_COPY, S_SWITCH,
    S_BACKUP, S_BDRAIN, S_RESTORE, S_REPLAY
  } phase_t;

  typedef struct packed {
    logic stall;      // unit under test stalled
    logic pwrOn;      // backup powered
    logic bkReset;    // backup held in reset
    logic bkLoad;     // copy status into backup
    logic origLoad;   // copy status back into original
    logic useBackup;  // output select on backup
    logic filter;     // split critical / deferred requests
    logic holdSel;    // refuse requests for unit under test
    logic replay;     // drain deferral queue to original
    logic bkStall;    // backup being drained
  } strobe_t;

  function automatic logic isCritical(input logic [1:0] kind);
    return !kind[1];
  endfunction

endpackage

// File: rtl/backup_switch_fifo.sv
module backup_switch_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  assign popData = mem[rdPtr];
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);

endmodule

// File: rtl/backup_switch_ctrl.sv
module backup_switch_ctrl
  import backup_switch_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 testStart,
  input  logic [UNIT_W-1:0]    testUnit,
  input  logic                 testEnd,
  input  logic [NUM_UNITS-1:0] origBusy,
  input  logic                 bkBusy,
  input  logic                 fifoEmpty,
  output strobe_t              st,
  output logic [UNIT_W-1:0]    sel
);
  phase_t phase, phaseNext;
  logic   selBusy;

  assign selBusy = origBusy[sel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= S_IDLE;
      sel   <= '0;
    end else begin
      phase <= phaseNext;
      if (phase == S_IDLE && testStart) sel <= testUnit;
    end
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      S_IDLE:    if (testStart)           phaseNext = S_DRAIN;
      S_DRAIN:   if (!selBusy)            phaseNext = S_POWER;
      S_POWER:                            phaseNext = S_COPY;
      S_COPY:                             phaseNext = S_SWITCH;
      S_SWITCH:  if (!selBusy && !bkBusy) phaseNext = S_BACKUP;
      S_BACKUP:  if (testEnd)             phaseNext = S_BDRAIN;
      S_BDRAIN:  if (!bkBusy)             phaseNext = S_RESTORE;
      S_RESTORE:                          phaseNext = S_REPLAY;
      S_REPLAY:  if (fifoEmpty)           phaseNext = S_IDLE;
      default:                            phaseNext = S_IDLE;
    endcase
  end

  always_comb begin
    st = '0;
    st.stall     = phase inside {S_DRAIN, S_POWER, S_COPY, S_SWITCH,
                                 S_BACKUP, S_BDRAIN, S_RESTORE};
    st.pwrOn     = phase inside {S_POWER, S_COPY, S_SWITCH, S_BACKUP,
                                 S_BDRAIN, S_RESTORE};
    st.bkReset   = (phase == S_POWER);
    st.bkLoad    = (phase == S_COPY);
    st.origLoad  = (phase == S_RESTORE);
    st.useBackup = phase inside {S_BACKUP, S_BDRAIN};
    st.filter    = (phase == S_BACKUP);
    st.holdSel   = phase inside {S_DRAIN, S_POWER, S_COPY, S_SWITCH,
                                 S_BDRAIN, S_RESTORE};
    st.replay    = (phase == S_REPLAY);
    st.bkStall   = (phase == S_BDRAIN);
  end

  // R3: status copy follows the backup reset cycle
  p_copy_after_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.bkLoad |-> $past(st.bkReset));
  // R6: select moves over only on a quiet cycle
  p_quiet_switch_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.useBackup) |-> $past(!origBusy[sel] && !bkBusy));
  p_quiet_return_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(st.useBackup) |-> $past(!bkBusy));
  // R8: restore only after the backup drained
  p_restore_after_drain_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.origLoad |-> $past(st.bkStall && !bkBusy));
  // R12: a start during a session leaves the selection alone
  p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rstN)
    (phase != S_IDLE && testStart) |=> $stable(sel));

endmodule

// File: rtl/backup_switch_dp.sv
module backup_switch_dp
  import backup_switch_pkg::*;
#(
  parameter int NUM_UNITS  = 4,
  parameter int UNIT_W     = 2,
  parameter int DATA_W     = 16,
  parameter int INT_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     st,
  input  logic [UNIT_W-1:0]           sel,
  input  logic                        reqValid,
  input  logic [UNIT_W-1:0]           reqUnit,
  input  logic [1:0]                  reqKind,
  input  logic [DATA_W-1:0]           reqData,
  output logic                        reqReady,
  output logic [1:0]                  fwdKind,
  output logic [DATA_W-1:0]           fwdData,
  output logic [NUM_UNITS-1:0]        origReqValid,
  output logic [NUM_UNITS-1:0]        origStall,
  input  logic [NUM_UNITS-1:0]        origRspValid,
  input  logic [NUM_UNITS*DATA_W-1:0] origRspData,
  input  logic [NUM_UNITS*INT_W-1:0]  origIntStatus,
  output logic [NUM_UNITS-1:0]        origIntLoad,
  output logic [INT_W-1:0]            origIntData,
  output logic                        bkPowerOn,
  output logic                        bkReset,
  output logic                        bkStall,
  output logic                        bkReqValid,
  input  logic                        bkRspValid,
  input  logic [DATA_W-1:0]           bkRspData,
  input  logic [INT_W-1:0]            bkIntStatus,
  output logic                        bkIntLoad,
  output logic [INT_W-1:0]            bkIntData,
  output logic [NUM_UNITS-1:0]        rspValid,
  output logic [NUM_UNITS*DATA_W-1:0] rspData,
  output logic                        fifoEmpty
);
  localparam int ITEM_W = DATA_W + 2;

  logic              hitSel, fwdValid, pushReq, popReq, fifoFull;
  logic [ITEM_W-1:0] headItem;

  assign hitSel = (reqUnit == sel);

  always_comb begin
    reqReady   = 1'b1;
    fwdValid   = 1'b0;
    bkReqValid = 1'b0;
    pushReq    = 1'b0;
    if (st.replay) begin
      reqReady = 1'b0;
    end else if (hitSel && st.holdSel) begin
      reqReady = 1'b0;
    end else if (hitSel && st.filter) begin
      if (isCritical(reqKind))  bkReqValid = reqValid;
      else if (fifoFull)        reqReady   = 1'b0;
      else                      pushReq    = reqValid;
    end else begin
      fwdValid = reqValid;
    end
  end

  assign popReq = st.replay && !fifoEmpty;
  assign {fwdKind, fwdData} = st.replay ? headItem : {reqKind, reqData};

  backup_switch_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ITEM_W)) i_deferQ (
    .clk(clk), .rstN(rstN),
    .push(pushReq), .pushData({reqKind, reqData}),
    .pop(popReq), .popData(headItem),
    .full(fifoFull), .empty(fifoEmpty)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic isSel;
    assign isSel = (sel == UNIT_W'(u));
    assign origReqValid[u] = st.replay ? (popReq && isSel)
                                       : (fwdValid && reqUnit == UNIT_W'(u));
    assign origStall[u]    = st.stall && isSel;
    assign origIntLoad[u]  = st.origLoad && isSel;
    assign rspValid[u]     = (st.useBackup && isSel) ? bkRspValid
                                                     : origRspValid[u];
    assign rspData[u*DATA_W +: DATA_W] = (st.useBackup && isSel) ? bkRspData
                                         : origRspData[u*DATA_W +: DATA_W];
  end

  assign bkPowerOn   = st.pwrOn;
  assign bkReset     = st.bkReset;
  assign bkStall     = st.bkStall;
  assign bkIntLoad   = st.bkLoad;
  assign bkIntData   = origIntStatus[sel*INT_W +: INT_W];
  assign origIntData = bkIntStatus;

  // R3: a stalled original is never handed a request
  p_stalled_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (origReqValid & origStall) == '0);
  // R5: only critical kinds ever reach the backup
  p_backup_critical_r5: assert property (@(posedge clk) disable iff (!rstN)
    bkReqValid |-> isCritical(fwdKind));
  // R4: backup is live whenever it is handed work
  p_backup_live_r4: assert property (@(posedge clk) disable iff (!rstN)
    bkReqValid |-> (bkPowerOn && !bkReset));

endmodule

// File: rtl/backup_switch.sv
module backup_switch
  import backup_switch_pkg::*;
#(
  parameter int NUM_UNITS  = 4,
  parameter int DATA_W     = 16,
  parameter int INT_W      = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        testStart,
  input  logic [UNIT_W-1:0]           testUnit,
  input  logic                        testEnd,
  output logic                        unitIsolated,
  input  logic                        reqValid,
  input  logic [UNIT_W-1:0]           reqUnit,
  input  logic [1:0]                  reqKind,
  input  logic [DATA_W-1:0]           reqData,
  output logic                        reqReady,
  output logic [1:0]                  fwdKind,
  output logic [DATA_W-1:0]           fwdData,
  output logic [NUM_UNITS-1:0]        origReqValid,
  output logic [NUM_UNITS-1:0]        origStall,
  input  logic [NUM_UNITS-1:0]        origBusy,
  input  logic [NUM_UNITS-1:0]        origRspValid,
  input  logic [NUM_UNITS*DATA_W-1:0] origRspData,
  input  logic [NUM_UNITS*INT_W-1:0]  origIntStatus,
  output logic [NUM_UNITS-1:0]        origIntLoad,
  output logic [INT_W-1:0]            origIntData,
  output logic                        bkPowerOn,
  output logic                        bkReset,
  output logic                        bkStall,
  output logic                        bkReqValid,
  input  logic                        bkBusy,
  input  logic                        bkRspValid,
  input  logic [DATA_W-1:0]           bkRspData,
  input  logic [INT_W-1:0]            bkIntStatus,
  output logic                        bkIntLoad,
  output logic [INT_W-1:0]            bkIntData,
  output logic [NUM_UNITS-1:0]        rspValid,
  output logic [NUM_UNITS*DATA_W-1:0] rspData
);
  strobe_t           st;
  logic [UNIT_W-1:0] sel;
  logic              fifoEmpty;

  backup_switch_ctrl #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .testStart(testStart), .testUnit(testUnit), .testEnd(testEnd),
    .origBusy(origBusy), .bkBusy(bkBusy), .fifoEmpty(fifoEmpty),
    .st(st), .sel(sel)
  );

  backup_switch_dp #(
    .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W), .DATA_W(DATA_W),
    .INT_W(INT_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .sel(sel),
    .reqValid(reqValid), .reqUnit(reqUnit), .reqKind(reqKind),
    .reqData(reqData), .reqReady(reqReady),
    .fwdKind(fwdKind), .fwdData(fwdData),
    .origReqValid(origReqValid), .origStall(origStall),
    .origRspValid(origRspValid), .origRspData(origRspData),
    .origIntStatus(origIntStatus), .origIntLoad(origIntLoad),
    .origIntData(origIntData),
    .bkPowerOn(bkPowerOn), .bkReset(bkReset), .bkStall(bkStall),
    .bkReqValid(bkReqValid), .bkRspValid(bkRspValid), .bkRspData(bkRspData),
    .bkIntStatus(bkIntStatus), .bkIntLoad(bkIntLoad), .bkIntData(bkIntData),
    .rspValid(rspValid), .rspData(rspData), .fifoEmpty(fifoEmpty)
  );

  assign unitIsolated = st.useBackup;

endmodule

// File: tb/test_backup_switch.sv
`timescale 1ns/100ps
module test_backup_switch;
  localparam int NU = 4;
  localparam int DW = 16;
  localparam int IW = 8;

  typedef struct packed { logic [1:0] kind; logic [DW-1:0] data; } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testStart = 1'b0, testEnd = 1'b0;
  logic [1:0] testUnit = '0;
  logic unitIsolated;
  logic reqValid = 1'b0;
  logic [1:0] reqUnit = '0, reqKind = '0;
  logic [DW-1:0] reqData = '0;
  logic reqReady;
  logic [1:0] fwdKind;
  logic [DW-1:0] fwdData;
  logic [NU-1:0] origReqValid, origStall, origIntLoad, rspValid;
  logic [NU-1:0] origBusy = '0, origRspValid = '0;
  logic [NU*DW-1:0] origRspData = '0, rspData;
  logic [NU*IW-1:0] origIntStatus = {8'h44, 8'h33, 8'h22, 8'h11};
  logic [IW-1:0] origIntData, bkIntData;
  logic [IW-1:0] bkIntStatus = 8'h5A;
  logic bkPowerOn, bkReset, bkStall, bkReqValid, bkIntLoad;
  logic bkBusy = 1'b0, bkRspValid = 1'b0;
  logic [DW-1:0] bkRspData = '0;

  int nChecks = 0;
  int nErrors = 0;
  item_t expQ [NU+1][$];

  always #2.5 clk = ~clk;

  backup_switch i_backup_switch (
    .clk(clk), .rstN(rstN), .testStart(testStart), .testUnit(testUnit),
    .testEnd(testEnd), .unitIsolated(unitIsolated),
    .reqValid(reqValid), .reqUnit(reqUnit), .reqKind(reqKind),
    .reqData(reqData), .reqReady(reqReady), .fwdKind(fwdKind),
    .fwdData(fwdData), .origReqValid(origReqValid), .origStall(origStall),
    .origBusy(origBusy), .origRspValid(origRspValid),
    .origRspData(origRspData), .origIntStatus(origIntStatus),
    .origIntLoad(origIntLoad), .origIntData(origIntData),
    .bkPowerOn(bkPowerOn), .bkReset(bkReset), .bkStall(bkStall),
    .bkReqValid(bkReqValid), .bkBusy(bkBusy), .bkRspValid(bkRspValid),
    .bkRspData(bkRspData), .bkIntStatus(bkIntStatus), .bkIntLoad(bkIntLoad),
    .bkIntData(bkIntData), .rspValid(rspValid), .rspData(rspData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: record the expected destination, then present the request
  task automatic send(input int unit, input logic [1:0] kind,
                      input logic [DW-1:0] data, input int dest);
    int waited = 0;
    expQ[dest].push_back({kind, data});
    reqValid = 1'b1; reqUnit = unit[1:0]; reqKind = kind; reqData = data;
    @(negedge clk);
    while (!reqReady && waited < 50) begin
      waited++;
      @(negedge clk);
    end
    chk(reqReady, "R2", "request acceptance", 32'(reqReady), 1);
    step(1);
    reqValid = 1'b0;
  endtask

  task automatic expectBlocked(input int unit, input logic [1:0] kind,
                               input logic [DW-1:0] data, input string req);
    reqValid = 1'b1; reqUnit = unit[1:0]; reqKind = kind; reqData = data;
    @(negedge clk);
    chk(!reqReady, req, "request refused", 32'(reqReady), 0);
    step(1);
    reqValid = 1'b0;
  endtask

  // monitor: pop and compare every request as it leaves the wrapper
  always @(negedge clk) begin
    if (rstN) begin
      for (int d = 0; d <= NU; d++) begin
        automatic logic fire = (d == NU) ? bkReqValid : origReqValid[d];
        if (fire) begin
          automatic string tag = (d == NU) ? "R5" : "R2/R9";
          if (expQ[d].size() == 0) begin
            chk(1'b0, tag, $sformatf("unexpected request at dest %0d", d),
                {14'd0, fwdKind, fwdData}, 0);
          end else begin
            automatic item_t e = expQ[d].pop_front();
            chk({fwdKind, fwdData} == e, tag,
                $sformatf("request content at dest %0d", d),
                {14'd0, fwdKind, fwdData}, {14'd0, e});
          end
        end
      end
    end
  end

  initial begin
    #1000000;
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chk(origStall == '0, "R1", "origStall after reset", 32'(origStall), 0);
    chk(!bkPowerOn && !bkReset, "R1", "backup off after reset",
        {30'd0, bkPowerOn, bkReset}, 0);
    chk(!unitIsolated, "R1", "select on original", 32'(unitIsolated), 0);
    chk(reqReady, "R1", "ready after reset", 32'(reqReady), 1);
    origRspValid = 4'b0100;
    origRspData[2*DW +: DW] = 16'h2222;
    bkRspValid = 1'b1; bkRspData = 16'hBBBB;
    #1;
    chk(rspValid == 4'b0100 && rspData[2*DW +: DW] == 16'h2222, "R7",
        "response from original when idle", 32'(rspData[2*DW +: DW]), 32'h2222);
    origRspValid = '0; bkRspValid = 1'b0;

    // R2 plain traffic to every unit, all kinds
    send(0, 2'd0, 16'h0100, 0);
    send(1, 2'd2, 16'h0201, 1);
    send(2, 2'd3, 16'h0302, 2);
    send(3, 2'd1, 16'h0403, 3);
    send(2, 2'd2, 16'h0304, 2);

    // session on unit 2, original still busy
    origBusy = 4'b0100; bkBusy = 1'b1;
    testStart = 1'b1; testUnit = 2'd2;
    step(1);
    testStart = 1'b0;
    chk(origStall == 4'b0100, "R3", "unit 2 stalled", 32'(origStall), 4);
    chk(!bkPowerOn, "R4", "backup off while draining", 32'(bkPowerOn), 0);
    expectBlocked(2, 2'd0, 16'h0BAD, "R3");
    send(1, 2'd2, 16'h0111, 1);  // R11 neighbour unaffected
    chk(!bkPowerOn, "R3", "backup waits for drain", 32'(bkPowerOn), 0);
    origBusy = '0;
    step(1);
    chk(bkPowerOn && bkReset, "R3", "power and reset cycle",
        {30'd0, bkPowerOn, bkReset}, 3);
    step(1);
    chk(bkIntLoad && bkIntData == 8'h33 && !bkReset, "R3",
        "status copy into backup", {23'd0, bkIntLoad, bkIntData}, 32'h133);
    step(1);
    chk(!unitIsolated, "R6", "select held while backup busy",
        32'(unitIsolated), 0);
    step(2);
    chk(!unitIsolated, "R6", "select still held", 32'(unitIsolated), 0);
    bkBusy = 1'b0;
    step(1);
    chk(unitIsolated, "R6", "select moved on quiet cycle",
        32'(unitIsolated), 1);

    // on backup: critical vs deferred (R5), neighbours (R11)
    send(2, 2'd0, 16'h0A00, NU);
    send(2, 2'd2, 16'h0C01, 2);
    send(2, 2'd1, 16'h0A02, NU);
    send(2, 2'd3, 16'h0C03, 2);
    send(0, 2'd2, 16'h0004, 0);
    send(2, 2'd2, 16'h0C05, 2);
    send(2, 2'd3, 16'h0C06, 2);
    expectBlocked(2, 2'd2, 16'h0DEA, "R10");
    send(2, 2'd0, 16'h0A07, NU);  // R10 critical passes while queue full

    // R7 response mux
    origRspValid = 4'b0110;
    origRspData = {16'h0000, 16'h2222, 16'h1111, 16'h0000};
    bkRspValid = 1'b1; bkRspData = 16'hBBBB;
    #1;
    chk(rspValid == 4'b0110 && rspData[2*DW +: DW] == 16'hBBBB, "R7",
        "unit 2 response from backup", 32'(rspData[2*DW +: DW]), 32'hBBBB);
    chk(rspData[DW +: DW] == 16'h1111, "R11", "unit 1 response untouched",
        32'(rspData[DW +: DW]), 32'h1111);
    bkRspValid = 1'b0;
    #1;
    chk(rspValid == 4'b0010, "R7", "original response masked",
        32'(rspValid), 32'h2);
    origRspValid = '0;

    // R12 start during session
    testStart = 1'b1; testUnit = 2'd0;
    step(1);
    testStart = 1'b0;
    step(1);
    chk(origStall == 4'b0100 && unitIsolated, "R12", "second start ignored",
        {27'd0, unitIsolated, origStall}, 32'h14);

    // R8 switch back
    testEnd = 1'b1; bkBusy = 1'b1;
    step(1);
    testEnd = 1'b0;
    chk(bkStall && unitIsolated, "R8", "backup draining",
        {30'd0, bkStall, unitIsolated}, 3);
    expectBlocked(2, 2'd0, 16'h0BAE, "R8");
    bkBusy = 1'b0;
    step(1);
    chk(origIntLoad == 4'b0100 && origIntData == 8'h5A, "R8",
        "status restored to original", {20'd0, origIntLoad, origIntData},
        32'h45A);
    chk(!unitIsolated, "R8", "select back on original", 32'(unitIsolated), 0);
    step(1);
    chk(!reqReady && origStall == '0, "R9", "replay blocks input",
        {27'd0, reqReady, origStall}, 0);
    step(6);
    chk(!bkPowerOn, "R4", "backup off after session", 32'(bkPowerOn), 0);
    chk(reqReady && origStall == '0, "R9", "input open after replay",
        {27'd0, reqReady, origStall}, 32'h10);
    send(2, 2'd2, 16'h0E00, 2);
    step(2);
    for (int d = 0; d <= NU; d++)
      chk(expQ[d].size() == 0, "R9", $sformatf("dest %0d drained", d),
          32'(expQ[d].size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule